// File: doc/BRIEF.md
# Multiphase Power-State Phase Shedding Controller

This block is the digital phase manager of a multiphase buck controller with up to six phases. It receives a decoded power-state command from the host link, a regulator-ready flag, a fault flag, a switching enable, static configuration bits and the per-phase PWM requests of an upstream modulator. For every phase it drives a three-level output code: high, low or tri-state.

It chooses how many phases stay active in each power state. Each phase is dropped or brought back only at that phase's own switching-period boundary, so no phase emits a partial pulse. In coupled-inductor setups the phase opposite phase 1 has a fixed role in the low-power states: it pulls its low side on while phase 1 is high, so the coupled current has a path to circulate. In the deepest states the one remaining phase can run in diode emulation. Low-power commands have no effect until the output has been declared ready.

Top module: `phase_shed_ctrl`

## Requirements
- R1: Each phase output is a 2-bit code: 2'b00 drives low, 2'b01 drives high, 2'b10 is tri-state. The code 2'b11 never appears. Phase k (0-based) uses bits [2k+1:2k] of `drv_o`.
- R2: When `fault_i` is high or `sw_en_i` is low, every phase outputs tri-state in that same cycle. A phase whose 0-based index is at or above `nph_i` is always tri-state.
- R3: After reset the block latches `ready_i`. The latched flag rises one clock after the first clock edge that samples `ready_i` high, and it stays set until reset. While the flag is clear, every command is handled as all-phase operation. Reset marks every phase as enabled.
- R4: `cmd_i` encoding: 0 = all phases, 1 = light load, 2 = very light load, 3 = ultra light load, 4 = decay. Codes 3 and 4 behave exactly like code 2. Codes 5 to 7 behave like code 0.
- R5: The enabled status of phase k changes only on a clock edge at which `edge_i[k]` is high. At that edge it takes the target computed from the current inputs and the latched ready flag.
- R6: In light-load mode, phase 0 is targeted. When `cfg_two_i` is set, the opposite phase with 0-based index `nph_i/2` is also targeted, provided that index is not 0.
- R7: In very-light, ultra-light and decay modes, only phase 0 is targeted, whatever the configuration.
- R8: An enabled phase drives high when its request bit is 1 and low when it is 0. The exception is phase 0 in very-light, ultra-light or decay mode with `cfg_de_i` set: it drives tri-state instead of low.
- R9: With `cfg_coupled_i` set and the mode not all-phase, a disabled opposite phase drives low while phase 0 is enabled and requesting high. Any other disabled phase drives tri-state.
- R10: On a return to all-phase mode, each configured phase is re-enabled at its own next `edge_i` pulse and then follows its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded power-state command |
| ready_i | input | 1 | Output declared ready after soft-start |
| fault_i | input | 1 | Fault present; tri-state everything |
| sw_en_i | input | 1 | Switching enable; low during the start delay |
| cfg_coupled_i | input | 1 | Coupled-inductor configuration |
| cfg_two_i | input | 1 | Two phases in light-load mode |
| cfg_de_i | input | 1 | Diode emulation in the deep low-power modes |
| nph_i | input | 3 | Number of configured phases, 1 to 6 |
| req_i | input | 6 | Per-phase PWM request from the modulator |
| edge_i | input | 6 | Per-phase switching-period start strobe |
| drv_o | output | 12 | Per-phase three-level output codes |

## Verification
Two functions can act on the same phase in the same cycle. A command change can land in the cycle where that phase's period strobe fires, while the coupled-low forcing of the opposite phase also depends on phase 0's request. The bench provokes this by driving random strobes, requests and commands together across every configuration and phase count, with the ready lockout and faults mixed in. A behavioural model keeps its own enable array and ready latch and predicts every phase code on every clock, so a re-add taken one strobe early or late, or a forced-low drive at the wrong moment, shows as a miscompare.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic [1:0] {
        DRV_LOW  = 2'b00,
        DRV_HIGH = 2'b01,
        DRV_TRI  = 2'b10
    } drv_t;

    typedef enum logic [1:0] {
        CLS_FULL  = 2'd0,
        CLS_LIGHT = 2'd1,
        CLS_DEEP  = 2'd2
    } cls_t;

    typedef struct packed {
        logic coupled;
        logic two;
        logic de;
    } cfg_t;

    // R4: command codes 3 and 4 fold onto 2; unknown codes mean all phases
    function automatic cls_t classify(input logic [2:0] cmd, input logic rdy);
        cls_t c;
        if (!rdy)
            c = CLS_FULL;
        else begin
            case (cmd)
                3'd1:                c = CLS_LIGHT;
                3'd2, 3'd3, 3'd4:    c = CLS_DEEP;
                default:             c = CLS_FULL;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/phs_mode_decode.sv
module phs_mode_decode
    import phs_pkg::*;
#(
    parameter int NPH_MAX = 6,
    parameter int CW      = $clog2(NPH_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ready,
    input  logic [2:0]         cmd,
    input  logic               two,
    input  logic [CW-1:0]      nph,
    output cls_t               cls,
    output logic [CW-1:0]      opp,
    output logic [NPH_MAX-1:0] target
);

    logic rdy_q;

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= rdy_q | ready;
    end

    assign cls = classify(cmd, rdy_q);
    assign opp = nph >> 1;

    for (genvar i = 0; i < NPH_MAX; i++) begin : g_tgt
        always_comb begin
            case (cls)
                CLS_LIGHT: target[i] = (i == 0) ||
                                       (two && (opp != '0) && (CW'(i) == opp));
                CLS_DEEP:  target[i] = (i == 0);
                default:   target[i] = (CW'(i) < nph);
            endcase
        end
    end

    // R3: no low-power class before the ready latch is set
    a_r3_lockout: assert property (@(posedge clk) disable iff (rst)
        !rdy_q |-> cls == CLS_FULL);

    // R7: deep modes target phase 0 alone
    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        cls == CLS_DEEP |-> target == NPH_MAX'(1));

endmodule

// File: rtl/phs_phase_gate.sv
module phs_phase_gate
    import phs_pkg::*;
#(
    parameter int IDX = 0,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_p,
    input  logic          tgt,
    input  logic          req,
    input  logic          ph1_high,
    input  cls_t          cls,
    input  cfg_t          cfg,
    input  logic [CW-1:0] nph,
    input  logic [CW-1:0] opp,
    input  logic          fault,
    input  logic          sw_en,
    output logic          en_o,
    output drv_t          drv
);

    logic en_q;
    logic is_opp;

    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b1;
        else if (edge_p) en_q <= tgt;
    end

    assign en_o   = en_q;
    assign is_opp = (CW'(IDX) == opp) && (opp != '0);

    always_comb begin
        if (fault || !sw_en || (CW'(IDX) >= nph))
            drv = DRV_TRI;
        else if (en_q) begin
            if (req)
                drv = DRV_HIGH;
            else if ((IDX == 0) && (cls == CLS_DEEP) && cfg.de)
                drv = DRV_TRI;
            else
                drv = DRV_LOW;
        end else if (cfg.coupled && (cls != CLS_FULL) && is_opp && ph1_high)
            drv = DRV_LOW;
        else
            drv = DRV_TRI;
    end

    // R1: reserved code never driven
    a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
        drv != 2'b11);

    // R2: fault tri-states the phase
    a_r2_fault_tri: assert property (@(posedge clk) disable iff (rst)
        fault |-> drv == DRV_TRI);

    // R5: enable status holds without a period strobe
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !edge_p |=> $stable(en_q));

endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl
    import phs_pkg::*;
#(
    parameter int NPH_MAX = 6,
    parameter int CW      = $clog2(NPH_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_i,
    input  logic                 ready_i,
    input  logic                 fault_i,
    input  logic                 sw_en_i,
    input  logic                 cfg_coupled_i,
    input  logic                 cfg_two_i,
    input  logic                 cfg_de_i,
    input  logic [CW-1:0]        nph_i,
    input  logic [NPH_MAX-1:0]   req_i,
    input  logic [NPH_MAX-1:0]   edge_i,
    output logic [2*NPH_MAX-1:0] drv_o
);

    cls_t               cls;
    logic [CW-1:0]      opp;
    logic [NPH_MAX-1:0] target;
    logic [NPH_MAX-1:0] en;
    cfg_t               cfg;
    logic               ph1_high;

    assign cfg      = '{coupled: cfg_coupled_i, two: cfg_two_i, de: cfg_de_i};
    assign ph1_high = en[0] & req_i[0];

    phs_mode_decode #(.NPH_MAX(NPH_MAX), .CW(CW)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .ready  (ready_i),
        .cmd    (cmd_i),
        .two    (cfg_two_i),
        .nph    (nph_i),
        .cls    (cls),
        .opp    (opp),
        .target (target)
    );

    for (genvar i = 0; i < NPH_MAX; i++) begin : g_ph
        drv_t d;
        phs_phase_gate #(.IDX(i), .CW(CW)) u_gate (
            .clk      (clk),
            .rst      (rst),
            .edge_p   (edge_i[i]),
            .tgt      (target[i]),
            .req      (req_i[i]),
            .ph1_high (ph1_high),
            .cls      (cls),
            .cfg      (cfg),
            .nph      (nph_i),
            .opp      (opp),
            .fault    (fault_i),
            .sw_en    (sw_en_i),
            .en_o     (en[i]),
            .drv      (d)
        );
        assign drv_o[2*i +: 2] = d;
    end

    // R10: a phase enabled in all-phase mode tracks its request
    a_r10_follow: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_FULL && en[0] && !fault_i && sw_en_i && nph_i != '0)
            |-> drv_o[1:0] == {1'b0, req_i[0]});

endmodule

// File: tb/phase_shed_ctrl_bench.sv
module phase_shed_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int WATCHDOG = 150000;

    logic           clk = 0;
    logic           rst = 1;
    logic [2:0]     cmd_i = 0;
    logic           ready_i = 0, fault_i = 0, sw_en_i = 0;
    logic           cfg_coupled_i = 0, cfg_two_i = 0, cfg_de_i = 0;
    logic [2:0]     nph_i = 3'd6;
    logic [NP-1:0]  req_i = 0, edge_i = 0;
    logic [2*NP-1:0] drv_o;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    // model state
    int m_en[NP];
    int m_rdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_shed_ctrl u_phase_shed_ctrl (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .ready_i(ready_i),
        .fault_i(fault_i), .sw_en_i(sw_en_i), .cfg_coupled_i(cfg_coupled_i),
        .cfg_two_i(cfg_two_i), .cfg_de_i(cfg_de_i), .nph_i(nph_i),
        .req_i(req_i), .edge_i(edge_i), .drv_o(drv_o)
    );

    // mode: 0 all, 1 light, 2 deep (R4 folding)
    function automatic int mode_of();
        if (m_rdy == 0) return 0;            // R3 lockout
        if (cmd_i == 3'd1) return 1;
        if (cmd_i >= 3'd2 && cmd_i <= 3'd4) return 2;
        return 0;
    endfunction

    function automatic int tgt_of(int i);
        int m = mode_of();
        int o = int'(nph_i) / 2;
        if (m == 1) return (i == 0 || (cfg_two_i && o != 0 && i == o)) ? 1 : 0; // R6
        if (m == 2) return (i == 0) ? 1 : 0;                                  // R7
        return (i < int'(nph_i)) ? 1 : 0;                                     // R10
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_en[i]) m_en[i] = 1;
            m_rdy = 0;
        end else begin
            int t[NP];
            for (int i = 0; i < NP; i++) t[i] = tgt_of(i);
            for (int i = 0; i < NP; i++) if (edge_i[i]) m_en[i] = t[i];       // R5
            if (ready_i) m_rdy = 1;
        end
    end

    task automatic check_all();
        int m = mode_of();
        int o = int'(nph_i) / 2;
        for (int i = 0; i < NP; i++) begin
            logic [1:0] exp_c, got;
            string tag;
            got = drv_o[2*i +: 2];
            if (fault_i || !sw_en_i || i >= int'(nph_i)) begin
                exp_c = 2'b10; tag = "R2";
            end else if (m_en[i] != 0) begin
                if (req_i[i]) exp_c = 2'b01;
                else if (i == 0 && m == 2 && cfg_de_i) exp_c = 2'b10;
                else exp_c = 2'b00;
                tag = (m_rdy == 0) ? "R3" : "R8";
            end else if (cfg_coupled_i && m != 0 && i == o && o != 0 &&
                         m_en[0] != 0 && req_i[0]) begin
                exp_c = 2'b00; tag = "R9";
            end else begin
                exp_c = 2'b10; tag = (m == 0) ? "R10" : "R5/R6/R7";
            end
            vectors++;
            if (got == 2'b11) begin
                miscompares++;
                $display("FAIL R1 phase %0d actual %b expected %b", i, got, exp_c);
            end else if (got !== exp_c) begin
                miscompares++;
                $display("FAIL %s phase %0d cmd %0d actual %b expected %b",
                         tag, i, cmd_i, got, exp_c);
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_drive(int fault_rate);
        req_i   = NP'($urandom);
        edge_i  = NP'($urandom) & NP'($urandom);
        fault_i = (($urandom % 100) < fault_rate);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int cfg = 0; cfg < 48; cfg++) begin
            cfg_coupled_i = cfg[0];
            cfg_two_i     = cfg[1];
            cfg_de_i      = cfg[2];
            nph_i         = 3'((cfg >> 3) + 1);
            // reset state: all configured phases follow request (R3)
            rst = 1; ready_i = 0; sw_en_i = 0; fault_i = 0;
            cmd_i = 3'd2; req_i = '1; edge_i = '1;
            step(); step();
            rst = 0;
            step();                                   // start delay: R2
            sw_en_i = 1;
            // lockout: low-power commands ignored before ready (R3)
            for (int k = 0; k < 8; k++) begin
                cmd_i = 3'(1 + ($urandom % 4));
                rand_drive(0);
                step();
            end
            ready_i = 1;
            // every command code, R4 folding of 3/4 and 5..7
            for (int c = 0; c < 8; c++) begin
                cmd_i = 3'(c);
                for (int k = 0; k < 20; k++) begin
                    rand_drive(4);
                    step();
                end
                cmd_i = 3'd0;                         // R10 return
                for (int k = 0; k < 6; k++) begin
                    rand_drive(0);
                    step();
                end
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule